// File: doc/BRIEF.md
# System Control Coprocessor Register Block

This block decodes the coprocessor move instructions of a processor's system control unit. Each access carries a 4-bit register selector, a 5-bit operation code and, for writes, a 32-bit data word. The block holds four writable control words and answers reads of two fixed identity words. It also turns writes aimed at the maintenance selectors into one-cycle command pulses for the cache and address-translation logic outside the block.

Reads return data one cycle after the strobe. Writes update state at the clock edge of the strobe. Any access the decoder does not recognise raises a one-cycle error pulse one cycle after its strobe, and changes no state. Cache and TLB command pulses also come one cycle after the strobe. The write data is carried alongside as the line address.

Top module: `sysctl_cop`

## Requirements
- R1: After reset, reads of selectors 1, 2, 3 and 4 with operation 0 return zero.
- R2: A write with operation 0 to selector 1 (control), 2 (table base), 3 (fault status) or 4 (fault address) stores the data. A later read of the same selector with operation 0 returns it. The value is presented on `rd_data` in the cycle after the read strobe.
- R3: A read of selector 0 returns parameter `ID_WORD` for operation 0 and parameter `CACHE_WORD` for operation 1.
- R4: Selector 5 writes pulse one `cache_cmd` bit, one cycle after the strobe. The operation codes map to bits as follows: 28 gives bit 0, invalidate both caches. 20 gives bit 1, invalidate the instruction cache. 12 gives bit 2, invalidate the data cache. 10 gives bit 3, clean the data cache. 14 gives bit 4, flush the data cache. 13 gives bit 5, invalidate a data line. 11 gives bit 6, clean a data line. 15 gives bit 7, flush a data line. `cmd_addr` carries the write data in that same cycle.
- R5: A selector 6 write with an operation code from 2 to 6 inclusive pulses `tlb_flush` for one cycle, one cycle after the strobe.
- R6: A read that matches no valid selector and operation pair returns zero and pulses `err` one cycle after the strobe.
- R7: The following writes change no register, raise no command and pulse `err` one cycle after the strobe: a write to selectors 0 or 7 to 15; a write to selectors 1 to 4 with a nonzero operation; a write to selector 5 with an unlisted operation; a write to selector 6 with an operation outside 2 to 6.
- R8: `cache_cmd` has at most one bit set, and every pulse from `cache_cmd`, `tlb_flush` or `err` lasts exactly one cycle when accesses are not back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_vld | input | 1 | Access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 4 | Register selector |
| acc_op | input | 5 | Operation code |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid the cycle after a read strobe |
| cache_cmd | output | 8 | One-hot cache maintenance command pulse |
| tlb_flush | output | 1 | Flush-all-TLB pulse |
| cmd_addr | output | 32 | Data word that accompanies a command pulse |
| err | output | 1 | Unrecognised access pulse |

## Verification
The hardest case to reach is a rejected write that might still have disturbed the stored registers. At the ports, such a write shows only as an error pulse. The bench therefore first loads all four writable registers with distinct patterns. It then issues every kind of illegal write and reads all four registers back. The bench also sweeps the neighbouring codes around the listed cache operations and both ends of the TLB range, so that off-by-one decoding shows up.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int SEL_W  = 4;
  localparam int OP_W   = 5;
  localparam int DW     = 32;
  localparam int NCMD   = 8;
  localparam int NREG   = 4;

  typedef enum logic [2:0] {
    K_NONE, K_RDID, K_REG, K_CACHE, K_TLB, K_BAD
  } acc_kind_e;

  typedef struct packed {
    acc_kind_e        kind;
    logic [1:0]       reg_idx;
    logic [NCMD-1:0]  cmd_hot;
    logic             id_sel;
  } dec_t;

  // cache maintenance opcodes, bit index = position in this list
  function automatic logic [NCMD-1:0] cache_map(input logic [OP_W-1:0] op);
    logic [NCMD-1:0] h;
    h = '0;
    case (op)
      5'd28: h[0] = 1'b1;
      5'd20: h[1] = 1'b1;
      5'd12: h[2] = 1'b1;
      5'd10: h[3] = 1'b1;
      5'd14: h[4] = 1'b1;
      5'd13: h[5] = 1'b1;
      5'd11: h[6] = 1'b1;
      5'd15: h[7] = 1'b1;
      default: h = '0;
    endcase
    return h;
  endfunction
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int TLB_LO = 2,
  parameter int TLB_HI = 6
) (
  input  logic            vld,
  input  logic            wr,
  input  logic [SEL_W-1:0] sel,
  input  logic [OP_W-1:0]  op,
  output dec_t            dec
);
  logic op_zero;
  logic tlb_in_rng;

  always_comb begin
    op_zero    = (op == '0);
    tlb_in_rng = (int'(op) >= TLB_LO) && (int'(op) <= TLB_HI);
    dec        = '{kind: K_NONE, reg_idx: 2'd0, cmd_hot: '0, id_sel: 1'b0};
    if (vld) begin
      dec.kind = K_BAD;
      if (sel >= 4'd1 && sel <= 4'd4) begin
        dec.reg_idx = 2'(sel - 4'd1);
        if (op_zero) dec.kind = K_REG;
      end else if (sel == 4'd0) begin
        if (!wr && op <= 5'd1) begin
          dec.kind   = K_RDID;
          dec.id_sel = op[0];
        end
      end else if (sel == 4'd5) begin
        if (wr && cache_map(op) != '0) begin
          dec.kind    = K_CACHE;
          dec.cmd_hot = cache_map(op);
        end
      end else if (sel == 4'd6) begin
        if (wr && tlb_in_rng) dec.kind = K_TLB;
      end
    end
  end
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [1:0]    widx,
  input  logic [DW-1:0] wdata,
  input  logic [1:0]    ridx,
  output logic [DW-1:0] rval
);
  logic [DW-1:0] regs_q [NREG];
  logic [DW-1:0] regs_d [NREG];

  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      regs_d[i] = regs_q[i];
      if (we && widx == 2'(i)) regs_d[i] = wdata;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs_q[g] <= '0;
      else if (we) regs_q[g] <= regs_d[g];
    end
  end

  assign rval = regs_q[ridx];
endmodule

// File: rtl/sysctl_cop.sv
module sysctl_cop
  import sysctl_pkg::*;
#(
  parameter logic [31:0] ID_WORD    = 32'h4D11_0863,
  parameter logic [31:0] CACHE_WORD = 32'h0D15_2152,
  parameter int          TLB_LO     = 2,
  parameter int          TLB_HI     = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_vld,
  input  logic        acc_wr,
  input  logic [3:0]  acc_sel,
  input  logic [4:0]  acc_op,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic [7:0]  cache_cmd,
  output logic        tlb_flush,
  output logic [31:0] cmd_addr,
  output logic        err
);
  dec_t          dec;
  logic          reg_we;
  logic [DW-1:0] reg_val;
  logic [DW-1:0] rd_d, rd_q, addr_d, addr_q;
  logic [NCMD-1:0] cmd_d, cmd_q;
  logic          tlb_d, tlb_q, err_d, err_q;

  sysctl_decode #(.TLB_LO(TLB_LO), .TLB_HI(TLB_HI)) u_dec (
    .vld(acc_vld), .wr(acc_wr), .sel(acc_sel), .op(acc_op), .dec(dec)
  );

  assign reg_we = (dec.kind == K_REG) && acc_wr;

  sysctl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .widx(dec.reg_idx),
    .wdata(wr_data), .ridx(dec.reg_idx), .rval(reg_val)
  );

  always_comb begin
    rd_d   = '0;
    cmd_d  = '0;
    tlb_d  = 1'b0;
    err_d  = (dec.kind == K_BAD);
    addr_d = addr_q;
    if (acc_vld && !acc_wr) begin
      if (dec.kind == K_REG)  rd_d = reg_val;
      if (dec.kind == K_RDID) rd_d = dec.id_sel ? CACHE_WORD : ID_WORD;
    end else begin
      rd_d = rd_q;
    end
    if (dec.kind == K_CACHE) begin
      cmd_d  = dec.cmd_hot;
      addr_d = wr_data;
    end
    if (dec.kind == K_TLB) begin
      tlb_d  = 1'b1;
      addr_d = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= '0;
      cmd_q  <= '0;
      tlb_q  <= 1'b0;
      err_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      rd_q   <= rd_d;
      cmd_q  <= cmd_d;
      tlb_q  <= tlb_d;
      err_q  <= err_d;
      addr_q <= addr_d;
    end
  end

  assign rd_data   = rd_q;
  assign cache_cmd = cmd_q;
  assign tlb_flush = tlb_q;
  assign cmd_addr  = addr_q;
  assign err       = err_q;

  // R8: command vector one-hot or idle
  a_r8_cmd_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cache_cmd));
  // R8: no overlap of command, flush and error
  a_r8_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({|cache_cmd, tlb_flush, err}) <= 1);
  // R6/R7: no access, no error next cycle
  a_r7_err_needs_acc: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_vld |=> !err);
  // R5: TLB pulse only follows a selector 6 write
  a_r5_tlb_src: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_vld && acc_wr && acc_sel == 4'd6) |=> !tlb_flush);
  // R4: cache pulse only follows a selector 5 write
  a_r4_cache_src: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_vld && acc_wr && acc_sel == 4'd5) |=> cache_cmd == '0);
  // R3: identity read returns the fixed word
  a_r3_id_read: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && !acc_wr && acc_sel == 4'd0 && acc_op == 5'd0) |=> rd_data == ID_WORD);
  // R6: unmatched selector read gives zero
  a_r6_rd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && !acc_wr && acc_sel > 4'd4) |=> (rd_data == '0 && err));
endmodule

// File: tb/sim_sysctl_cop.sv
module sim_sysctl_cop;
  logic clk = 0, rst_n = 0;
  logic acc_vld = 0, acc_wr = 0;
  logic [3:0] acc_sel = 0;
  logic [4:0] acc_op = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] rd_data, cmd_addr;
  logic [7:0] cache_cmd;
  logic tlb_flush, err;
  int n_chk = 0, n_bad = 0;
  localparam logic [31:0] IDW = 32'h4D11_0863;
  localparam logic [31:0] CTW = 32'h0D15_2152;

  always #5 clk = ~clk;

  sysctl_cop u0 (.*);

  // vector: wr, sel, op, data, exp_cmd, exp_tlb, exp_err
  typedef struct packed {
    logic wr; logic [3:0] sel; logic [4:0] op; logic [31:0] d;
    logic [7:0] cmd; logic tlb; logic er;
  } vec_t;
  localparam int NV = 20;
  localparam vec_t VT [NV] = '{
    '{1'b1, 4'd5, 5'd28, 32'hA0, 8'h01, 1'b0, 1'b0},
    '{1'b1, 4'd5, 5'd20, 32'hA1, 8'h02, 1'b0, 1'b0},
    '{1'b1, 4'd5, 5'd12, 32'hA2, 8'h04, 1'b0, 1'b0},
    '{1'b1, 4'd5, 5'd10, 32'hA3, 8'h08, 1'b0, 1'b0},
    '{1'b1, 4'd5, 5'd14, 32'hA4, 8'h10, 1'b0, 1'b0},
    '{1'b1, 4'd5, 5'd13, 32'hA5, 8'h20, 1'b0, 1'b0},
    '{1'b1, 4'd5, 5'd11, 32'hA6, 8'h40, 1'b0, 1'b0},
    '{1'b1, 4'd5, 5'd15, 32'hA7, 8'h80, 1'b0, 1'b0},
    '{1'b1, 4'd5, 5'd9,  32'h0,  8'h00, 1'b0, 1'b1},
    '{1'b1, 4'd5, 5'd16, 32'h0,  8'h00, 1'b0, 1'b1},
    '{1'b1, 4'd5, 5'd29, 32'h0,  8'h00, 1'b0, 1'b1},
    '{1'b1, 4'd6, 5'd2,  32'hB2, 8'h00, 1'b1, 1'b0},
    '{1'b1, 4'd6, 5'd6,  32'hB6, 8'h00, 1'b1, 1'b0},
    '{1'b1, 4'd6, 5'd1,  32'h0,  8'h00, 1'b0, 1'b1},
    '{1'b1, 4'd6, 5'd7,  32'h0,  8'h00, 1'b0, 1'b1},
    '{1'b1, 4'd0, 5'd0,  32'h0,  8'h00, 1'b0, 1'b1},
    '{1'b1, 4'd7, 5'd0,  32'h0,  8'h00, 1'b0, 1'b1},
    '{1'b1, 4'd2, 5'd1,  32'h0,  8'h00, 1'b0, 1'b1},
    '{1'b0, 4'd5, 5'd28, 32'h0,  8'h00, 1'b0, 1'b1},
    '{1'b1, 4'd15,5'd0,  32'h0,  8'h00, 1'b0, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, strobe sampled at next posedge; outputs valid after it
  task automatic acc(input logic w, input logic [3:0] s, input logic [4:0] o, input logic [31:0] d);
    @(negedge clk);
    acc_vld = 1; acc_wr = w; acc_sel = s; acc_op = o; wr_data = d;
    @(negedge clk);
    acc_vld = 0; acc_wr = 0;
  endtask

  task automatic rd(input logic [3:0] s, input logic [4:0] o, output logic [31:0] v);
    acc(1'b0, s, o, 32'h0);
    v = rd_data;
  endtask

  initial begin : wd
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int i = 1; i <= 4; i++) begin
      rd(4'(i), 5'd0, v); check("R1", v, 32'h0);
    end
    check("R8 idle", {23'h0, cache_cmd, tlb_flush}, 32'h0);
    // vector table: R4 R5 R7
    for (int i = 0; i < NV; i++) begin
      acc(VT[i].wr, VT[i].sel, VT[i].op, VT[i].d);
      check(VT[i].sel == 4'd5 ? "R4 cmd" : "R7 cmd", {24'h0, cache_cmd}, {24'h0, VT[i].cmd});
      check("R5 tlb", {31'h0, tlb_flush}, {31'h0, VT[i].tlb});
      check("R7 err", {31'h0, err}, {31'h0, VT[i].er});
      if (VT[i].cmd != 0 || VT[i].tlb) check("R4 addr", cmd_addr, VT[i].d);
      @(negedge clk);
      check("R8 pulse width", {23'h0, cache_cmd, tlb_flush, err}, 32'h0);
    end
    // R2 write/read
    for (int i = 1; i <= 4; i++) acc(1'b1, 4'(i), 5'd0, 32'h1111_0000 * i + 32'(i));
    for (int i = 1; i <= 4; i++) begin
      rd(4'(i), 5'd0, v); check("R2", v, 32'h1111_0000 * i + 32'(i));
    end
    // R7 illegal writes leave registers intact
    for (int i = 1; i <= 4; i++) acc(1'b1, 4'(i), 5'd3, 32'hDEAD_BEEF);
    acc(1'b1, 4'd0, 5'd1, 32'hDEAD_BEEF);
    acc(1'b1, 4'd9, 5'd0, 32'hDEAD_BEEF);
    acc(1'b1, 4'd5, 5'd0, 32'hDEAD_BEEF);
    for (int i = 1; i <= 4; i++) begin
      rd(4'(i), 5'd0, v); check("R7 hold", v, 32'h1111_0000 * i + 32'(i));
    end
    // R3 identity
    rd(4'd0, 5'd0, v); check("R3 id", v, IDW);
    rd(4'd0, 5'd1, v); check("R3 cache", v, CTW);
    check("R3 no err", {31'h0, err}, 32'h0);
    // R6 unmatched reads
    rd(4'd0, 5'd2, v); check("R6 zero", v, 32'h0); check("R6 err", {31'h0, err}, 32'h1);
    rd(4'd3, 5'd1, v); check("R6 zero", v, 32'h0); check("R6 err", {31'h0, err}, 32'h1);
    rd(4'd6, 5'd2, v); check("R6 zero", v, 32'h0); check("R6 err", {31'h0, err}, 32'h1);
    // R1 again after reset mid-run
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    rd(4'd2, 5'd0, v); check("R1 re-reset", v, 32'h0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule